// File: doc/BRIEF.md
# Serial programming row-erase sequencer

This block is the host-side controller that erases one 64-byte row of flash in a target device over a two-wire serial programming link. The link has a programming clock, always driven by the host, and a programming data line. Every transaction on the link is a 4-bit command followed by a 16-bit payload. Each of the 20 bits goes out least significant bit first. The data line changes only while the clock is low, and the target takes each bit on the falling clock edge.

A single start pulse, together with a row address, launches a fixed script of ten transactions. Six of them load the three bytes of the target's table pointer from the address. Three more set the erase-enable, write-enable and start bits of the target's flash control register. The last is a no-operation whose fourth clock is held high for the erase time. A clock-low discharge interval follows it, and then the empty payload. The erase time and the discharge time are parameters counted in system clock cycles, and so is the clock half-period. If the protection input is high when start arrives, nothing is driven on the link and the block pulses an error output.

Top module: `rowerase_seq`

## Requirements
- R1: While reset is held, and on the first cycle after it, pgc_o, pgd_o, busy_o, done_o and err_o are all 0.
- R2: Each transaction is 20 bits. The 4 command bits go first, then the 16 payload bits, each field least significant bit first. The target takes each bit on a falling edge of pgc_o. pgd_o never changes while pgc_o stays high.
- R3: One erase issues exactly ten transactions, all with command 4'b0000. Their payloads, in order, are: 16'h0E00|U, 16'h6EF8, 16'h0E00|H, 16'h6EF7, 16'h0E00|L, 16'h6EF6, 16'h88A6, 16'h84A6, 16'h82A6 and 16'h0000. Here U is address bits 21:16 zero-extended to a byte, H is bits 15:8 and L is bits 7:0. The address bits come from the address held at start, with bits 5:0 unmodified.
- R4: Outside the stretched pulse, pgc_o stays high for HALF_CYC cycles. Between bits of one transaction it stays low for HALF_CYC cycles. Between two transactions it stays low for HALF_CYC+2 cycles.
- R5: The fourth clock of the tenth transaction stays high for ERASE_CYC cycles, and pgd_o is 0 throughout.
- R6: After that stretched pulse falls, pgc_o stays low for DISCH_CYC+HALF_CYC cycles before the fifth clock rises, so the low time is at least DISCH_CYC.
- R7: busy_o rises the cycle after an accepted start. It stays high until the last falling edge of the sequence, and it falls in the same cycle that done_o goes high for exactly one cycle. A start while busy_o is high has no effect on the ongoing transactions, and no second sequence follows.
- R8: A start with prot_i high drives no clock edge. busy_o stays low and done_o is not pulsed. err_o is high for exactly the one cycle after the start.
- R9: pgc_o is low whenever busy_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request one row erase |
| addr_i | input | ADDR_W | Any byte address inside the row to erase |
| prot_i | input | 1 | The row lies in a protected block |
| busy_o | output | 1 | A sequence is running |
| done_o | output | 1 | One-cycle pulse at the end of a sequence |
| err_o | output | 1 | One-cycle pulse when a start is refused |
| pgc_o | output | 1 | Programming clock to the target |
| pgd_o | output | 1 | Programming data to the target |

## Verification
Random row addresses exercise the pointer-byte payloads across the whole address range. A mix of protected and unprotected starts shows that the refusal path never toggles the clock. Directed addresses of all zeros, all ones and low bits 6'h3F show that the row offset passes through unmodified and that bytes are placed correctly at the extremes. Each clock high and low run is timed against its own rule, so an ordinary bit, a transaction gap, the stretched erase pulse and the discharge gap are all told apart. A start injected mid-sequence with a different address shows whether the held address and the running script are disturbed.

// File: rtl/rowerase_pkg.sv
package rowerase_pkg;
   localparam int CMD_BITS    = 4;
   localparam int PAY_BITS    = 16;
   localparam int FRAME_BITS  = CMD_BITS + PAY_BITS;
   localparam int N_XACT      = 10;
   localparam int STRETCH_BIT = 3;

   localparam logic [3:0]  CORE_CMD   = 4'b0000;
   localparam logic [7:0]  OP_LOADIMM = 8'h0E;
   localparam logic [7:0]  OP_STORE   = 8'h6E;
   localparam logic [7:0]  REG_PTR_U  = 8'hF8;
   localparam logic [7:0]  REG_PTR_H  = 8'hF7;
   localparam logic [7:0]  REG_PTR_L  = 8'hF6;
   localparam logic [15:0] SET_ERASE  = 16'h88A6;
   localparam logic [15:0] SET_WREN   = 16'h84A6;
   localparam logic [15:0] SET_GO     = 16'h82A6;

   typedef enum logic [1:0] {PH_IDLE, PH_LO, PH_HI, PH_DIS} phase_t;
endpackage

// File: rtl/rowerase_steps.sv
module rowerase_steps
   import rowerase_pkg::*;
#(
   parameter int ADDR_W = 22
) (
   input  logic [3:0]        idx_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic [3:0]        cmd_o,
   output logic [15:0]       pay_o,
   output logic              stretch_o
);
   logic [23:0] a24;

   generate
      if (ADDR_W < 7 || ADDR_W > 24) begin : g_bad_width
         $error("rowerase_steps: ADDR_W must lie in 7..24");
      end
      if (ADDR_W == 24) begin : g_full
         assign a24 = addr_i;
      end else begin : g_ext
         assign a24 = {{(24-ADDR_W){1'b0}}, addr_i};
      end
   endgenerate

   always_comb begin
      cmd_o     = CORE_CMD;
      stretch_o = 1'b0;
      case (idx_i)
         4'd0:    pay_o = {OP_LOADIMM, a24[23:16]};
         4'd1:    pay_o = {OP_STORE, REG_PTR_U};
         4'd2:    pay_o = {OP_LOADIMM, a24[15:8]};
         4'd3:    pay_o = {OP_STORE, REG_PTR_H};
         4'd4:    pay_o = {OP_LOADIMM, a24[7:0]};
         4'd5:    pay_o = {OP_STORE, REG_PTR_L};
         4'd6:    pay_o = SET_ERASE;
         4'd7:    pay_o = SET_WREN;
         4'd8:    pay_o = SET_GO;
         default: begin
            pay_o     = 16'h0000;
            stretch_o = 1'b1;
         end
      endcase
   end
endmodule

// File: rtl/rowerase_shift.sv
module rowerase_shift
   import rowerase_pkg::*;
#(
   parameter int HALF_CYC  = 2,
   parameter int ERASE_CYC = 400,
   parameter int DISCH_CYC = 100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go_i,
   input  logic [3:0]  cmd_i,
   input  logic [15:0] pay_i,
   input  logic        stretch_i,
   output logic        fin_o,
   output logic        pgc_o,
   output logic        pgd_o
);
   localparam int MAX_A = (ERASE_CYC > DISCH_CYC) ? ERASE_CYC : DISCH_CYC;
   localparam int MAX_C = (MAX_A > HALF_CYC) ? MAX_A : HALF_CYC;
   localparam int CW    = $clog2(MAX_C + 1);
   localparam int BW    = $clog2(FRAME_BITS);

   generate
      if (HALF_CYC < 1)         begin : g_bad_half  $error("HALF_CYC must be >= 1");  end
      if (ERASE_CYC < HALF_CYC) begin : g_bad_erase $error("ERASE_CYC must be >= HALF_CYC"); end
      if (DISCH_CYC < 1)        begin : g_bad_disch $error("DISCH_CYC must be >= 1"); end
   endgenerate

   phase_t                ph;
   logic [CW-1:0]         cnt;
   logic [BW-1:0]         bitn;
   logic [FRAME_BITS-1:0] sr;
   logic                  str_q;
   logic                  at_stretch;

   assign at_stretch = str_q && (bitn == BW'(STRETCH_BIT));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph    <= PH_IDLE;
         cnt   <= '0;
         bitn  <= '0;
         sr    <= '0;
         str_q <= 1'b0;
         fin_o <= 1'b0;
      end else begin
         fin_o <= 1'b0;
         case (ph)
            PH_IDLE: if (go_i) begin
               sr    <= {pay_i, cmd_i};
               str_q <= stretch_i;
               bitn  <= '0;
               cnt   <= CW'(HALF_CYC - 1);
               ph    <= PH_LO;
            end
            PH_LO: if (cnt == '0) begin
               ph  <= PH_HI;
               cnt <= at_stretch ? CW'(ERASE_CYC - 1) : CW'(HALF_CYC - 1);
            end else begin
               cnt <= cnt - 1'b1;
            end
            PH_HI: if (cnt == '0) begin
               if (at_stretch) begin
                  ph  <= PH_DIS;
                  cnt <= CW'(DISCH_CYC - 1);
               end else if (bitn == BW'(FRAME_BITS - 1)) begin
                  ph    <= PH_IDLE;
                  fin_o <= 1'b1;
               end else begin
                  ph   <= PH_LO;
                  cnt  <= CW'(HALF_CYC - 1);
                  sr   <= sr >> 1;
                  bitn <= bitn + 1'b1;
               end
            end else begin
               cnt <= cnt - 1'b1;
            end
            default: if (cnt == '0) begin
               ph   <= PH_LO;
               cnt  <= CW'(HALF_CYC - 1);
               sr   <= sr >> 1;
               bitn <= bitn + 1'b1;
            end else begin
               cnt <= cnt - 1'b1;
            end
         endcase
      end
   end

   assign pgc_o = (ph == PH_HI);
   assign pgd_o = ((ph == PH_LO) || (ph == PH_HI)) ? sr[0] : 1'b0;

   // R2: data is frozen across a high clock phase
   p_data_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pgc_o && $past(pgc_o)) |-> $stable(pgd_o));

   // R2: bit index stays inside the 20-bit frame
   p_bit_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      bitn < BW'(FRAME_BITS));

   // R5: data stays low for the whole stretched pulse
   p_stretch_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_HI && at_stretch) |-> !pgd_o);

   // R6: the discharge phase is always entered from the stretched pulse
   p_disch_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ph == PH_DIS) |-> $past(ph == PH_HI && at_stretch));
endmodule

// File: rtl/rowerase_seq.sv
module rowerase_seq
   import rowerase_pkg::*;
#(
   parameter int ADDR_W    = 22,
   parameter int HALF_CYC  = 2,
   parameter int ERASE_CYC = 400,
   parameter int DISCH_CYC = 100
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              prot_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              err_o,
   output logic              pgc_o,
   output logic              pgd_o
);
   logic [ADDR_W-1:0] addr_q;
   logic [3:0]        idx;
   logic              go_q;
   logic              fin;
   logic [3:0]        cmd;
   logic [15:0]       pay;
   logic              stretch;

   rowerase_steps #(.ADDR_W(ADDR_W)) u_steps (
      .idx_i(idx), .addr_i(addr_q), .cmd_o(cmd), .pay_o(pay), .stretch_o(stretch)
   );

   rowerase_shift #(
      .HALF_CYC(HALF_CYC), .ERASE_CYC(ERASE_CYC), .DISCH_CYC(DISCH_CYC)
   ) u_shift (
      .clk(clk), .rst_n(rst_n), .go_i(go_q), .cmd_i(cmd), .pay_i(pay),
      .stretch_i(stretch), .fin_o(fin), .pgc_o(pgc_o), .pgd_o(pgd_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
         go_q   <= 1'b0;
         idx    <= '0;
         addr_q <= '0;
      end else begin
         go_q   <= 1'b0;
         done_o <= 1'b0;
         err_o  <= 1'b0;
         if (!busy_o) begin
            if (start_i) begin
               if (prot_i) begin
                  err_o <= 1'b1;
               end else begin
                  busy_o <= 1'b1;
                  addr_q <= addr_i;
                  idx    <= '0;
                  go_q   <= 1'b1;
               end
            end
         end else if (fin) begin
            if (idx == 4'(N_XACT - 1)) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
            end else begin
               idx  <= idx + 1'b1;
               go_q <= 1'b1;
            end
         end
      end
   end

   // R9: link clock parked low outside a sequence
   p_idle_clock_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !pgc_o);

   // R7: busy only begins in answer to a start
   p_busy_from_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i && !prot_i));

   // R7: busy ends exactly with the done pulse
   p_done_ends_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R7: done lasts one cycle
   p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   // R8: a refusal never overlaps a sequence
   p_err_alone_r8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && !done_o && $past(prot_i)));

   // R3: the address used by the script holds still during a sequence
   p_addr_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(addr_q));
endmodule

// File: tb/sim_rowerase_seq.sv
module sim_rowerase_seq;
   localparam int AW    = 22;
   localparam int HALF  = 2;
   localparam int ERASE = 400;
   localparam int DISCH = 100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic [AW-1:0] addr = '0;
   logic prot = 1'b0;
   logic busy, done, err, pgc, pgd;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   rowerase_seq #(.ADDR_W(AW), .HALF_CYC(HALF), .ERASE_CYC(ERASE), .DISCH_CYC(DISCH)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(addr), .prot_i(prot),
      .busy_o(busy), .done_o(done), .err_o(err), .pgc_o(pgc), .pgd_o(pgd)
   );

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_pay(input int i, input logic [AW-1:0] a);
      logic [23:0] w;
      w = 24'(a);
      case (i)
         0: exp_pay = {8'h0E, w[23:16]};
         1: exp_pay = 16'h6EF8;
         2: exp_pay = {8'h0E, w[15:8]};
         3: exp_pay = 16'h6EF7;
         4: exp_pay = {8'h0E, w[7:0]};
         5: exp_pay = 16'h6EF6;
         6: exp_pay = 16'h88A6;
         7: exp_pay = 16'h84A6;
         8: exp_pay = 16'h82A6;
         default: exp_pay = 16'h0000;
      endcase
   endfunction

   // link monitor
   logic [19:0] word [10];
   int  bc = 0;
   int  rc = 0;
   logic pgc_p = 1'b0, pgd_p = 1'b0, done_p = 1'b0;
   int  done_cnt = 0;
   int  busy_seen = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy) busy_seen++;
         if (pgc && pgc_p) chk(pgd == pgd_p, "R2 data moved while clock high", pgd, pgd_p);
         if (!busy) chk(!pgc, "R9 clock high while idle", pgc, 0);
         if (done) begin
            done_cnt++;
            chk(!busy, "R7 busy with done", busy, 0);
            chk(!done_p, "R7 done longer than one cycle", 1, 0);
         end
         if (pgc != pgc_p) begin
            if (pgc_p) begin
               int x, p, eh;
               x  = bc / 20;
               p  = bc % 20;
               eh = (x == 9 && p == 3) ? ERASE : HALF;
               chk(rc == eh, (x == 9 && p == 3) ? "R5 stretched high time" : "R4 high time", rc, eh);
               if (x == 9 && p == 3) chk(pgd_p == 1'b0, "R5 data low in stretch", pgd_p, 0);
               if (x < 10) word[x][p] = pgd_p;
               bc++;
            end else if (bc > 0) begin
               int x, p, el;
               x  = bc / 20;
               p  = bc % 20;
               el = (x == 9 && p == 4) ? DISCH + HALF : (p == 0) ? HALF + 2 : HALF;
               chk(rc == el, (x == 9 && p == 4) ? "R6 discharge low time" : "R4 low time", rc, el);
            end
            rc = 1;
         end else begin
            rc++;
         end
      end
      pgc_p  = pgc;
      pgd_p  = pgd;
      done_p = done;
   end

   task automatic run_erase(input logic [AW-1:0] a, input bit interrupt);
      int d0;
      @(negedge clk);
      bc = 0;
      d0 = done_cnt;
      start = 1'b1; addr = a; prot = 1'b0;
      @(negedge clk);
      start = 1'b0; addr = ~a;
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      if (interrupt) begin
         repeat (300) @(negedge clk);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      for (int k = 0; k < 20000 && done_cnt == d0; k++) @(negedge clk);
      chk(done_cnt == d0 + 1, "R7 done pulse count", done_cnt - d0, 1);
      chk(bc == 200, "R3 bit count", bc, 200);
      for (int i = 0; i < 10; i++) begin
         chk(word[i][3:0] == 4'b0000, "R3 command field", word[i][3:0], 0);
         chk(word[i][19:4] == exp_pay(i, a), "R3 payload", word[i][19:4], exp_pay(i, a));
      end
      repeat (40) @(negedge clk);
      chk(!busy && bc == 200, "R7 no extra sequence", bc, 200);
   endtask

   task automatic run_refused(input logic [AW-1:0] a);
      int d0, b0;
      @(negedge clk);
      bc = 0; d0 = done_cnt; b0 = busy_seen;
      start = 1'b1; addr = a; prot = 1'b1;
      @(negedge clk);
      start = 1'b0; prot = 1'b0;
      chk(err == 1'b1, "R8 err after refused start", err, 1);
      chk(busy == 1'b0, "R8 busy stays low", busy, 0);
      @(negedge clk);
      chk(err == 1'b0, "R8 err single cycle", err, 0);
      repeat (30) @(negedge clk);
      chk(bc == 0 && busy_seen == b0, "R8 no clock activity", bc, 0);
      chk(done_cnt == d0, "R8 no done", done_cnt - d0, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL R7 watchdog actual=hang expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      int unsigned s;
      s = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      chk({pgc, pgd, busy, done, err} == 5'b0, "R1 outputs in reset", {pgc, pgd, busy, done, err}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk({pgc, pgd, busy, done, err} == 5'b0, "R1 outputs after reset", {pgc, pgd, busy, done, err}, 0);
      run_erase(22'h000000, 1'b0);
      run_erase(22'h3FFFFF, 1'b0);
      run_erase(22'h12343F, 1'b0);
      run_erase(22'h2A5A40, 1'b1);
      run_refused(22'h001000);
      for (int n = 0; n < 16; n++) begin
         logic [AW-1:0] ra;
         ra = AW'($urandom);
         if (($urandom % 5) == 0) run_refused(ra);
         else run_erase(ra, 1'b0);
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule